// File: doc/BRIEF.md
# Nibble-Field Prioritised Interrupt Controller

This block collects 28 interrupt sources and presents the CPU with one priority level and one vector number. Each source has its own 4-bit field in one of four 32-bit control words. The low three bits of a field hold the source's priority, and a priority of zero masks the source. The top bit of the field is a write strobe. Software can therefore change one source with a single store and no read-modify-write: it writes the field it wants with the strobe set and writes every other field as zero.

Six sources come from outside the chip and are edge sensitive. Each external pin passes through a two-flop synchroniser. An edge detector then watches it, and a per-source polarity bit picks the rising or the falling edge. A detected edge sets a latched pending flag. Software clears that flag by writing the source's field with the strobe set, so masking an external source also acknowledges it. The other 22 sources are internal and level sensitive: while the input is high the source is pending, and nothing is latched.

At every clock the block finds, among sources that are pending and not masked, the one with the highest priority. A tie goes to the lowest vector number. The block registers that source's priority and vector onto its outputs. When nothing qualifies, both outputs are zero, and vector 0 stands for a spurious request.

Top module: `intc_nibble_ctrl`

## Requirements
- R1: After reset every priority is 0, no source is pending, the polarity bits are 0, and `irq_level` and `irq_vector` are both 0. Every readable word returns 0.
- R2: Source vector v (1..28) is driven on `src_in[v-1]`. Its field sits in control word (v-1)/8, at word address 0..3, starting at bit 28-4*((v-1)%8). The polarity word is at address 4.
- R3: A write whose field has bit 3 set loads bits 2:0 of that field as the new priority. A write whose field has bit 3 clear leaves that source's priority unchanged.
- R4: A source with priority 0 never appears on the outputs, even while it is pending.
- R5: An internal source (every vector except 1, 2, 3, 4, 26, 27) is pending exactly while its input is high, with no latching. Writing its field with bit 3 set has no effect on its pending state.
- R6: External sources are vectors 1, 2, 3, 4, 26 and 27, which use polarity bits 0..5 in that order. Polarity 1 selects the rising edge and 0 the falling edge. A selected edge sets a pending flag within 3 clocks. The flag stays set after the input returns, and an edge of the other direction does nothing.
- R7: A write with bit 3 set in an external source's field clears that source's pending flag. If an edge is detected in the same clock as that write, the flag stays set.
- R8: One clock after the internal state changes, `irq_level` shows the highest priority among pending unmasked sources and `irq_vector` shows that source's vector. On a tie the lowest vector wins.
- R9: When no pending source has a non-zero priority, `irq_level` and `irq_vector` are both 0.
- R10: Reading a control word returns, in each field, the priority in bits 2:0 and the current pending state in bit 3. In word 3, bits 15:0 read 0 and ignore writes. The polarity word reads back in bits 5:0, and addresses 5..7 read 0.
- R11: Writing 0x88888888 to all four control words masks every source and clears every external pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one word per clock |
| bus_addr | input | 3 | Word address: 0..3 control words, 4 polarity |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| src_in | input | 28 | Source inputs, bit v-1 is vector v |
| irq_level | output | 3 | Registered winning priority, 0 when idle |
| irq_vector | output | 5 | Registered winning vector, 0 when idle |

## Verification
The arbiter is tried with four kinds of input: a single active source, two sources tied at the same priority, a higher priority arriving above a pending one, and a pending source that is masked. Together these separate max-selection, the lowest-vector tie rule and the masking rule. The external path is driven with pulses in both directions under both polarities. This shows that only the selected edge latches and that the flag survives the input dropping. Writes are then aimed at the strobe bit: strobe-clear writes, strobe-set writes on internal sources, an acknowledge that lands in the same clock as a fresh edge, and the full mask-all sequence. These distinguish a per-field strobe from a whole-word load, and set-priority from clear-priority on the pending flag.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NUM_SRC        = 28;
    localparam int NUM_EXT        = 6;
    localparam int PRIO_W         = 3;
    localparam int FIELD_W        = PRIO_W + 1;
    localparam int DATA_W         = 32;
    localparam int FIELDS_PER_REG = DATA_W / FIELD_W;
    localparam int NUM_CREG       = (NUM_SRC + FIELDS_PER_REG - 1) / FIELDS_PER_REG;
    localparam int ADDR_W         = 3;
    localparam int VEC_W          = $clog2(NUM_SRC + 1);
    localparam int SYNC_STAGES    = 2;
    localparam int POL_ADDR       = NUM_CREG;

    // control word holding source index i (vector i+1)
    function automatic int creg_of(input int i);
        return i / FIELDS_PER_REG;
    endfunction

    // lowest bit of source i's field; first vector of a word sits at the top
    function automatic int lsb_of(input int i);
        return DATA_W - FIELD_W - FIELD_W * (i % FIELDS_PER_REG);
    endfunction

    // source index served by external line k
    function automatic int ext_src(input int k);
        return (k < 4) ? k : k + 21;
    endfunction

    function automatic bit is_ext(input int i);
        bit hit;
        hit = 1'b0;
        for (int k = 0; k < NUM_EXT; k++) begin
            if (ext_src(k) == i) hit = 1'b1;
        end
        return hit;
    endfunction

    function automatic int ext_line(input int i);
        int line;
        line = 0;
        for (int k = 0; k < NUM_EXT; k++) begin
            if (ext_src(k) == i) line = k;
        end
        return line;
    endfunction
endpackage

// File: rtl/intc_edge_sync.sv
module intc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic rise_sel,
    output logic edge_hit
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    always_comb begin
        if (rise_sel) edge_hit = sync_q[STAGES-1] & ~last_q;
        else          edge_hit = ~sync_q[STAGES-1] & last_q;
    end
endmodule

// File: rtl/intc_src_bank.sv
module intc_src_bank
    import intc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    input  logic [NUM_SRC-1:0]           src_in,
    input  logic [NUM_EXT-1:0]           ext_edge,
    output logic [NUM_SRC*PRIO_W-1:0]    prio_flat,
    output logic [NUM_SRC-1:0]           pend,
    output logic [NUM_CREG*DATA_W-1:0]   creg_rd
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int CREG = creg_of(i);
        localparam int LSB  = lsb_of(i);

        logic              strobe;
        logic [PRIO_W-1:0] prio_q;

        assign strobe = bus_wr && (bus_addr == ADDR_W'(CREG)) && bus_wdata[LSB+PRIO_W];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      prio_q <= '0;
            else if (strobe) prio_q <= bus_wdata[LSB +: PRIO_W];
        end

        if (is_ext(i)) begin : g_ext
            localparam int LINE = ext_line(i);
            logic pend_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)              pend_q <= 1'b0;
                else if (ext_edge[LINE]) pend_q <= 1'b1;
                else if (strobe)         pend_q <= 1'b0;
            end
            assign pend[i] = pend_q;
        end else begin : g_int
            assign pend[i] = src_in[i];
        end

        assign prio_flat[i*PRIO_W +: PRIO_W]  = prio_q;
        assign creg_rd[CREG*DATA_W + LSB +: FIELD_W] = {pend[i], prio_q};
    end

    // fields with no source behind them
    for (genvar f = NUM_SRC; f < NUM_CREG*FIELDS_PER_REG; f++) begin : g_pad
        assign creg_rd[creg_of(f)*DATA_W + lsb_of(f) +: FIELD_W] = '0;
    end
endmodule

// File: rtl/intc_prio_arb.sv
module intc_prio_arb
    import intc_pkg::*;
(
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [NUM_SRC-1:0]        pend,
    output logic [PRIO_W-1:0]         win_level,
    output logic [VEC_W-1:0]          win_vector
);
    always_comb begin
        win_level  = '0;
        win_vector = '0;
        // strict compare: the lowest vector keeps a tie
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && (prio_flat[i*PRIO_W +: PRIO_W] > win_level)) begin
                win_level  = prio_flat[i*PRIO_W +: PRIO_W];
                win_vector = VEC_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/intc_nibble_ctrl.sv
module intc_nibble_ctrl
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [27:0]       src_in,
    output logic [2:0]        irq_level,
    output logic [4:0]        irq_vector
);
    logic [NUM_EXT-1:0]         pol_q;
    logic [NUM_EXT-1:0]         ext_edge;
    logic [NUM_SRC*PRIO_W-1:0]  prio_flat;
    logic [NUM_SRC-1:0]         pend;
    logic [NUM_CREG*DATA_W-1:0] creg_rd;
    logic [PRIO_W-1:0]          win_level;
    logic [VEC_W-1:0]           win_vector;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                         pol_q <= '0;
        else if (bus_wr && bus_addr == ADDR_W'(POL_ADDR))   pol_q <= bus_wdata[NUM_EXT-1:0];
    end

    for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
        intc_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_in   (src_in[ext_src(k)]),
            .rise_sel (pol_q[k]),
            .edge_hit (ext_edge[k])
        );
    end

    intc_src_bank bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .src_in    (src_in),
        .ext_edge  (ext_edge),
        .prio_flat (prio_flat),
        .pend      (pend),
        .creg_rd   (creg_rd)
    );

    intc_prio_arb arb_i (
        .prio_flat  (prio_flat),
        .pend       (pend),
        .win_level  (win_level),
        .win_vector (win_vector)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_level  <= '0;
            irq_vector <= '0;
        end else begin
            irq_level  <= win_level;
            irq_vector <= win_vector;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < ADDR_W'(NUM_CREG))
            bus_rdata = creg_rd[bus_addr*DATA_W +: DATA_W];
        else if (bus_addr == ADDR_W'(POL_ADDR))
            bus_rdata = {{(DATA_W-NUM_EXT){1'b0}}, pol_q};
    end
endmodule

// File: rtl/intc_nibble_chk.sv
module intc_nibble_chk
    import intc_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_wr,
    input logic [2:0]                  bus_addr,
    input logic [31:0]                 bus_wdata,
    input logic [2:0]                  irq_level,
    input logic [4:0]                  irq_vector,
    input logic [NUM_SRC*PRIO_W-1:0]   prio_flat,
    input logic [NUM_SRC-1:0]          pend,
    input logic [NUM_EXT-1:0]          ext_edge
);
    logic [NUM_SRC*PRIO_W-1:0] prev_prio;
    logic [NUM_SRC-1:0]        prev_pend;
    logic [VEC_W-1:0]          win_idx;
    logic [PRIO_W-1:0]         win_prio;
    logic                      win_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_prio <= '0;
            prev_pend <= '0;
        end else begin
            prev_prio <= prio_flat;
            prev_pend <= pend;
        end
    end

    assign win_idx  = (irq_vector == '0) ? '0 : irq_vector - 1'b1;
    assign win_prio = prev_prio[win_idx*PRIO_W +: PRIO_W];
    assign win_pend = prev_pend[win_idx];

    AST_IDLE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vector == '0) == (irq_level == '0));  // R9

    AST_WINNER_QUALIFIES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vector != '0) |-> (win_pend && win_prio == irq_level && win_prio != '0));  // R4

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_max
        AST_NO_HIGHER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            prev_pend[i] |-> (irq_level >= prev_prio[i*PRIO_W +: PRIO_W]));  // R8
    end

    AST_STROBE_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && !bus_wdata[31]) |=> $stable(prio_flat[PRIO_W-1:0]));  // R3

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && bus_wdata[31] && !ext_edge[0]) |=> !pend[0]);  // R7

    AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && !(bus_wr && bus_addr == 3'd0 && bus_wdata[31])) |=> pend[0]);  // R6
endmodule

bind intc_nibble_ctrl intc_nibble_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq_level  (irq_level),
    .irq_vector (irq_vector),
    .prio_flat  (prio_flat),
    .pend       (pend),
    .ext_edge   (ext_edge)
);

// File: tb/intc_nibble_ctrl_tb.sv
module intc_nibble_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [27:0] src_in = '0;
    logic [2:0]  irq_level;
    logic [4:0]  irq_vector;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [2:0] lvl;
        logic [4:0] vec;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    intc_nibble_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .src_in     (src_in),
        .irq_level  (irq_level),
        .irq_vector (irq_vector)
    );

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic read_check(input logic [2:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        n_tests++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: addr %0d read %h expected %h", tag, a, bus_rdata, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic expect_out(input logic [2:0] lvl, input logic [4:0] vec, input string tag);
        exp_t e;
        e.lvl = lvl;
        e.vec = vec;
        e.tag = tag;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
    endtask

    // monitor side
    initial begin
        forever begin
            exp_t e;
            wait (sb_q.size() != 0);
            #2;
            e = sb_q.pop_front();
            n_tests++;
            if (irq_level !== e.lvl || irq_vector !== e.vec) begin
                n_fail++;
                $display("FAIL %s: level/vector %0d/%0d expected %0d/%0d",
                         e.tag, irq_level, irq_vector, e.lvl, e.vec);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(1);

        // R1 reset state
        expect_out(3'd0, 5'd0, "R1 reset outputs");
        for (int a = 0; a < 5; a++) read_check(3'(a), 32'h0, "R1 reset readback");

        // R2 R3 priority 5 for vector 5 (word 0, bits 15:12)
        reg_write(3'd0, 32'h0000_D000);
        read_check(3'd0, 32'h0000_5000, "R2 R3 field placement");
        settle(1);
        expect_out(3'd0, 5'd0, "R9 idle with no input");

        // R5 R8 internal level source
        src_in[4] = 1'b1;
        settle(1);
        expect_out(3'd5, 5'd5, "R8 single source");
        read_check(3'd0, 32'h0000_D000, "R10 pending bit readback");

        // R3 strobe clear leaves field
        reg_write(3'd0, 32'h0000_0000);
        read_check(3'd0, 32'h0000_D000, "R3 strobe clear no change");

        // R8 tie: vector 9 also priority 5
        reg_write(3'd1, 32'hD000_0000);
        src_in[8] = 1'b1;
        settle(2);
        expect_out(3'd5, 5'd5, "R8 tie lowest vector");
        reg_write(3'd1, 32'hE000_0000);
        settle(1);
        expect_out(3'd6, 5'd9, "R8 higher priority wins");

        // R5 no latching
        src_in[4] = 1'b0;
        src_in[8] = 1'b0;
        settle(1);
        expect_out(3'd0, 5'd0, "R5 R9 level drop");

        // R5 strobe on internal source has no ack effect
        src_in[8] = 1'b1;
        reg_write(3'd1, 32'hE000_0000);
        read_check(3'd1, 32'hE000_0000, "R5 internal not acked");
        settle(1);
        expect_out(3'd6, 5'd9, "R5 internal still active");

        // R4 masking
        reg_write(3'd1, 32'h8000_0000);
        read_check(3'd1, 32'h8000_0000, "R4 masked still pending");
        settle(1);
        expect_out(3'd0, 5'd0, "R4 masked source hidden");
        src_in[8] = 1'b0;

        // R6 external vector 1, falling polarity by default
        reg_write(3'd0, 32'hB000_0000);
        src_in[0] = 1'b1;
        settle(5);
        read_check(3'd0, 32'h3000_5000, "R6 rising ignored on falling polarity");
        expect_out(3'd0, 5'd0, "R6 no pending on wrong edge");
        src_in[0] = 1'b0;
        settle(3);
        read_check(3'd0, 32'hB000_5000, "R6 falling edge latched within 3");
        settle(1);
        expect_out(3'd3, 5'd1, "R6 external latched output");

        // R7 acknowledge by strobe write
        reg_write(3'd0, 32'hB000_0000);
        read_check(3'd0, 32'h3000_5000, "R7 ack clears pending");
        settle(1);
        expect_out(3'd0, 5'd0, "R7 output after ack");

        // R6 rising polarity
        reg_write(3'd4, 32'h0000_0001);
        read_check(3'd4, 32'h0000_0001, "R10 polarity readback");
        src_in[0] = 1'b1;
        settle(5);
        expect_out(3'd3, 5'd1, "R6 rising edge latched");
        reg_write(3'd0, 32'h3000_0000);
        read_check(3'd0, 32'hB000_5000, "R7 strobe clear keeps pending");

        // R6 vector 27 (word 3, bits 23:20) falling pulse, priority 7
        reg_write(3'd3, 32'h00F0_0000);
        src_in[26] = 1'b1;
        settle(5);
        src_in[26] = 1'b0;
        settle(5);
        read_check(3'd3, 32'h00F0_0000, "R6 vector 27 latched");
        expect_out(3'd7, 5'd27, "R8 vector 27 above vector 1");

        // R10 unused fields of word 3
        reg_write(3'd3, 32'h0000_FFFF);
        read_check(3'd3, 32'h00F0_0000, "R10 unused fields ignored");
        read_check(3'd6, 32'h0, "R10 unmapped address");

        // R11 mask-all sequence
        for (int a = 0; a < 4; a++) reg_write(3'(a), 32'h8888_8888);
        read_check(3'd0, 32'h0, "R11 word 0 cleared");
        read_check(3'd3, 32'h0, "R11 word 3 cleared");
        settle(1);
        expect_out(3'd0, 5'd0, "R11 all masked");

        // R7 edge in the same clock as an acknowledge: set wins
        src_in[0] = 1'b0;
        settle(5);
        src_in[0] = 1'b1;
        settle(2);
        reg_write(3'd0, 32'hB000_0000);
        read_check(3'd0, 32'hB000_0000, "R7 edge beats ack");
        settle(1);
        expect_out(3'd3, 5'd1, "R7 pending survives ack");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule